// File: doc/BRIEF.md
# Triggered Region-Fill Write Master

This block is a memory-mapped bus master in programmable logic that fills a fixed buffer in processor-side DRAM on request. Software raises a control line to start a run. The master then writes a 256-byte region at byte address 0x0000_1000 as 64 words of 32 bits. It sends the data as two 16-beat incrementing bursts on a 64-bit AXI4 write channel and collects one write response per burst. When every response has arrived, it raises an interrupt that stays high until software acknowledges it on a second control line. The acknowledge re-arms the block, so the logic that fills the buffer and the processor that reads it take turns on the same region in a continuous loop.

The data is a 32-bit counter that starts from zero at the beginning of every run. Two counter values are packed into each beat, lower value in the lower half, so the reader can check the buffer contents directly. When the read-back option is enabled (the default), the master reads the whole region back over the AXI4 read channel after the writes and before it raises the interrupt, and compares every beat with the pattern. Bad bus responses and read-back mismatches each set a sticky flag that only reset clears.

Top module: `fill_master`

## Requirements
- R1: A run starts only on a 0-to-1 transition of `start_i` seen while the block is idle and the interrupt is low. A transition during a run or while the interrupt is pending starts no new bus traffic. While the interrupt is high, `m_awvalid`, `m_wvalid` and `m_arvalid` are all low.
- R2: Each run issues exactly two write addresses: 0x0000_1000, then 0x0000_1080. Each has burst length field 15 (16 beats), size code 3 (8 bytes) and burst type code 1 (incrementing).
- R3: Each run sends 32 write beats with all eight byte strobes set. `m_wlast` is high on the 16th beat of each burst and on no other beat.
- R4: Write beat n (n = 0 to 31) carries the word 2n in bits 31:0 and the word 2n+1 in bits 63:32. The count restarts from 0 on every run.
- R5: Once `m_awvalid` or `m_wvalid` is high, it stays high, and its address or data and last flag stay unchanged, until the matching ready is seen.
- R6: `irq_o` rises only after a write response has been accepted for both bursts of the run, and, with read-back enabled, after all 32 read beats have been received.
- R7: `irq_o` stays high until a 0-to-1 transition of `clear_i` is seen. It is low from the next cycle on, and the next start then produces a new clean 0-to-1 interrupt edge.
- R8: A write or read response other than OKAY (code 0) sets `resp_err_o`, which stays set until reset.
- R9: With read-back enabled, each run reads the region back with two 16-beat incrementing bursts at the same two addresses. If any beat's data differs from the R4 pattern, or its last flag is not on the 16th beat, `data_err_o` is set and stays set until reset.
- R10: While `rst_n` is low at a clock edge, the block returns to idle with `irq_o`, `resp_err_o`, `data_err_o` and every valid output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Run request from software; its rising edge counts |
| clear_i | input | 1 | Interrupt acknowledge; its rising edge counts |
| irq_o | output | 1 | Run-complete interrupt, held until acknowledged |
| resp_err_o | output | 1 | Sticky flag for a non-OKAY bus response |
| data_err_o | output | 1 | Sticky flag for a read-back mismatch |
| m_awaddr | output | 32 | Write burst address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 64 | Write data |
| m_wstrb | output | 8 | Write byte strobes |
| m_wlast | output | 1 | Last beat of a write burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read burst address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 64 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Last beat of a read burst |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The properties assume that the responding memory returns exactly one write response for each completed write burst, and never returns a response before that burst's last beat. They also assume that software changes `start_i` and `clear_i` only on whole clock cycles. The bench plays the memory side itself. It grants write data only for an address it has already accepted, queues one response per last beat, and returns read beats only for addresses it has accepted. Ready and valid are throttled by several cycle-modulo patterns, so every ordering the bursts can meet stays within those assumptions.

// File: rtl/fill_pkg.sv
// Shared definitions for the region-fill master.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package fill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DONE  = 2'd3
    } run_state_t;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/fill_ctrl.sv
// Run sequencer: detects software edges, launches write and read passes,
// owns the interrupt and the sticky error flags.
// Assumes: start_i and clear_i are synchronous to clk.
module fill_ctrl
    import fill_pkg::*;
#(
    parameter bit READBACK = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clear_i,
    input  logic wr_done,
    input  logic wr_err,
    input  logic rd_done,
    input  logic rd_err,
    input  logic rd_mismatch,
    output logic kick_wr,
    output logic kick_rd,
    output logic irq_o,
    output logic resp_err_o,
    output logic data_err_o
);
    run_state_t state;
    logic       start_q;
    logic       clear_q;
    logic       start_edge;
    logic       clear_edge;

    // Rising-edge detection of the two software control lines.
    assign start_edge = start_i && !start_q;
    assign clear_edge = clear_i && !clear_q;

    // Run state machine and interrupt register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            start_q <= 1'b0;
            clear_q <= 1'b0;
            kick_wr <= 1'b0;
            kick_rd <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            start_q <= start_i;
            clear_q <= clear_i;
            kick_wr <= 1'b0;
            kick_rd <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_edge) begin
                        state   <= ST_WRITE;
                        kick_wr <= 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (wr_done) begin
                        if (READBACK) begin
                            state   <= ST_READ;
                            kick_rd <= 1'b1;
                        end else begin
                            state <= ST_DONE;
                            irq_o <= 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_done) begin
                        state <= ST_DONE;
                        irq_o <= 1'b1;
                    end
                end
                default: begin
                    if (clear_edge) begin
                        state <= ST_IDLE;
                        irq_o <= 1'b0;
                    end
                end
            endcase
        end
    end

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_err_o <= 1'b0;
            data_err_o <= 1'b0;
        end else begin
            resp_err_o <= resp_err_o || wr_err || rd_err;
            data_err_o <= data_err_o || rd_mismatch;
        end
    end
endmodule

// File: rtl/fill_wr_engine.sv
// Write pass: issues the address bursts, streams the counter pattern, and
// counts write responses. Pulses done after the last response.
// Assumes: the slave returns one response per burst, after its last beat.
module fill_wr_engine
    import fill_pkg::*;
#(
    parameter int                 ADDR_W      = 32,
    parameter int                 DATA_W      = 64,
    parameter int                 WORD_W      = 32,
    parameter int                 BEATS_TOTAL = 32,
    parameter int                 BURST_BEATS = 16,
    parameter logic [ADDR_W-1:0]  BASE_ADDR   = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    output logic [ADDR_W-1:0] awaddr,
    output logic              awvalid,
    input  logic              awready,
    output logic [DATA_W-1:0] wdata,
    output logic              wlast,
    output logic              wvalid,
    input  logic              wready,
    input  logic [1:0]        bresp,
    input  logic              bvalid,
    output logic              bready,
    output logic              done,
    output logic              err
);
    localparam int LANES       = DATA_W / WORD_W;
    localparam int BURSTS      = BEATS_TOTAL / BURST_BEATS;
    localparam int BURST_BYTES = BURST_BEATS * (DATA_W / 8);
    localparam int BCW         = $clog2(BURSTS + 1);
    localparam int TCW         = $clog2(BEATS_TOTAL + 1);
    localparam int PW          = $clog2(BURST_BEATS);

    logic           active;
    logic [BCW-1:0] aw_cnt;
    logic [BCW-1:0] b_cnt;
    logic [TCW-1:0] w_cnt;

    assign awvalid = active && (aw_cnt < BCW'(BURSTS));
    assign awaddr  = BASE_ADDR + ADDR_W'(aw_cnt) * ADDR_W'(BURST_BYTES);
    assign wvalid  = active && (w_cnt < TCW'(BEATS_TOTAL));
    assign wlast   = (w_cnt[PW-1:0] == PW'(BURST_BEATS - 1));
    assign bready  = active && (b_cnt < BCW'(BURSTS));

    // One counter word per lane, lowest word in the lowest lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wdata[l*WORD_W +: WORD_W] = WORD_W'(int'(w_cnt) * LANES + l);
    end

    // Pass progress: address, beat and response counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            aw_cnt <= '0;
            b_cnt  <= '0;
            w_cnt  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (kick && !active) begin
                active <= 1'b1;
                aw_cnt <= '0;
                b_cnt  <= '0;
                w_cnt  <= '0;
            end else if (active) begin
                if (awvalid && awready) aw_cnt <= aw_cnt + 1'b1;
                if (wvalid && wready)   w_cnt  <= w_cnt + 1'b1;
                if (bvalid && bready) begin
                    b_cnt <= b_cnt + 1'b1;
                    err   <= (bresp != RESP_OKAY);
                    if (b_cnt == BCW'(BURSTS - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fill_rd_engine.sv
// Read-back pass: issues read bursts over the region and compares every
// beat and its last flag with the expected counter pattern.
// Assumes: beats return in address order, one burst after another.
module fill_rd_engine
    import fill_pkg::*;
#(
    parameter int                 ADDR_W      = 32,
    parameter int                 DATA_W      = 64,
    parameter int                 WORD_W      = 32,
    parameter int                 BEATS_TOTAL = 32,
    parameter int                 BURST_BEATS = 16,
    parameter logic [ADDR_W-1:0]  BASE_ADDR   = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    output logic [ADDR_W-1:0] araddr,
    output logic              arvalid,
    input  logic              arready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rlast,
    input  logic              rvalid,
    output logic              rready,
    output logic              done,
    output logic              err,
    output logic              mismatch
);
    localparam int LANES       = DATA_W / WORD_W;
    localparam int BURSTS      = BEATS_TOTAL / BURST_BEATS;
    localparam int BURST_BYTES = BURST_BEATS * (DATA_W / 8);
    localparam int BCW         = $clog2(BURSTS + 1);
    localparam int TCW         = $clog2(BEATS_TOTAL + 1);
    localparam int PW          = $clog2(BURST_BEATS);

    logic              active;
    logic [BCW-1:0]    ar_cnt;
    logic [TCW-1:0]    r_cnt;
    logic [DATA_W-1:0] expect_beat;
    logic              expect_last;

    assign arvalid     = active && (ar_cnt < BCW'(BURSTS));
    assign araddr      = BASE_ADDR + ADDR_W'(ar_cnt) * ADDR_W'(BURST_BYTES);
    assign rready      = active && (r_cnt < TCW'(BEATS_TOTAL));
    assign expect_last = (r_cnt[PW-1:0] == PW'(BURST_BEATS - 1));

    // Expected beat, built the same way the write pass packs it.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign expect_beat[l*WORD_W +: WORD_W] = WORD_W'(int'(r_cnt) * LANES + l);
    end

    // Pass progress and per-beat comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            ar_cnt   <= '0;
            r_cnt    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            mismatch <= 1'b0;
        end else begin
            done     <= 1'b0;
            err      <= 1'b0;
            mismatch <= 1'b0;
            if (kick && !active) begin
                active <= 1'b1;
                ar_cnt <= '0;
                r_cnt  <= '0;
            end else if (active) begin
                if (arvalid && arready) ar_cnt <= ar_cnt + 1'b1;
                if (rvalid && rready) begin
                    r_cnt    <= r_cnt + 1'b1;
                    err      <= (rresp != RESP_OKAY);
                    mismatch <= (rdata != expect_beat) || (rlast != expect_last);
                    if (r_cnt == TCW'(BEATS_TOTAL - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fill_master.sv
// Top of the region-fill master: sequencer plus write and optional
// read-back engines on one AXI4 master port.
// Assumes: BURST_BEATS is a power of two that divides the beat count,
// DATA_W is a multiple of WORD_W.
module fill_master
    import fill_pkg::*;
#(
    parameter int                 ADDR_W      = 32,
    parameter int                 DATA_W      = 64,
    parameter int                 WORD_W      = 32,
    parameter int                 WORDS       = 64,
    parameter int                 BURST_BEATS = 16,
    parameter logic [ADDR_W-1:0]  BASE_ADDR   = 32'h0000_1000,
    parameter bit                 READBACK    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clear_i,
    output logic              irq_o,
    output logic              resp_err_o,
    output logic              data_err_o,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [7:0]        m_arlen,
    output logic [2:0]        m_arsize,
    output logic [1:0]        m_arburst,
    output logic              m_arvalid,
    input  logic              m_arready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [1:0]        m_rresp,
    input  logic              m_rlast,
    input  logic              m_rvalid,
    output logic              m_rready
);
    localparam int BEATS_TOTAL = WORDS * WORD_W / DATA_W;
    localparam int BURSTS      = BEATS_TOTAL / BURST_BEATS;
    localparam int SIZE_CODE   = $clog2(DATA_W / 8);

    logic kick_wr, kick_rd;
    logic wr_done, wr_err;
    logic rd_done, rd_err, rd_mismatch;

    // Fixed burst shape for both directions.
    assign m_awlen   = 8'(BURST_BEATS - 1);
    assign m_awsize  = 3'(SIZE_CODE);
    assign m_awburst = BURST_INCR;
    assign m_wstrb   = '1;
    assign m_arlen   = 8'(BURST_BEATS - 1);
    assign m_arsize  = 3'(SIZE_CODE);
    assign m_arburst = BURST_INCR;

    fill_ctrl #(.READBACK(READBACK)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .clear_i     (clear_i),
        .wr_done     (wr_done),
        .wr_err      (wr_err),
        .rd_done     (rd_done),
        .rd_err      (rd_err),
        .rd_mismatch (rd_mismatch),
        .kick_wr     (kick_wr),
        .kick_rd     (kick_rd),
        .irq_o       (irq_o),
        .resp_err_o  (resp_err_o),
        .data_err_o  (data_err_o)
    );

    fill_wr_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W),
        .BEATS_TOTAL(BEATS_TOTAL), .BURST_BEATS(BURST_BEATS), .BASE_ADDR(BASE_ADDR)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (kick_wr),
        .awaddr  (m_awaddr),
        .awvalid (m_awvalid),
        .awready (m_awready),
        .wdata   (m_wdata),
        .wlast   (m_wlast),
        .wvalid  (m_wvalid),
        .wready  (m_wready),
        .bresp   (m_bresp),
        .bvalid  (m_bvalid),
        .bready  (m_bready),
        .done    (wr_done),
        .err     (wr_err)
    );

    // Read-back engine present only when the option is enabled.
    if (READBACK) begin : g_rd
        fill_rd_engine #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W),
            .BEATS_TOTAL(BEATS_TOTAL), .BURST_BEATS(BURST_BEATS), .BASE_ADDR(BASE_ADDR)
        ) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .kick     (kick_rd),
            .araddr   (m_araddr),
            .arvalid  (m_arvalid),
            .arready  (m_arready),
            .rdata    (m_rdata),
            .rresp    (m_rresp),
            .rlast    (m_rlast),
            .rvalid   (m_rvalid),
            .rready   (m_rready),
            .done     (rd_done),
            .err      (rd_err),
            .mismatch (rd_mismatch)
        );
    end else begin : g_no_rd
        assign m_araddr    = '0;
        assign m_arvalid   = 1'b0;
        assign m_rready    = 1'b0;
        assign rd_done     = 1'b0;
        assign rd_err      = 1'b0;
        assign rd_mismatch = 1'b0;
    end
endmodule

// File: rtl/fill_master_chk.sv
// Protocol and handshake checker for the region-fill master, bound to it.
// Assumes: one write response per burst, issued after that burst's last beat.
module fill_master_chk #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int BURSTS      = 2,
    parameter int BURST_BEATS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              irq_o,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_wlast,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic              m_bvalid,
    input logic              m_bready,
    input logic              m_arvalid
);
    logic        clr_q;
    logic [15:0] b_seen;
    logic [15:0] w_pos;

    // Mirror of acknowledge edge, response count and beat position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q  <= 1'b0;
            b_seen <= '0;
            w_pos  <= '0;
        end else begin
            clr_q  <= clear_i;
            if (irq_o)                      b_seen <= '0;
            else if (m_bvalid && m_bready)  b_seen <= b_seen + 16'd1;
            if (m_wvalid && m_wready)
                w_pos <= (w_pos == 16'(BURST_BEATS - 1)) ? 16'd0 : w_pos + 16'd1;
        end
    end

    p_quiet_when_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!m_awvalid && !m_wvalid && !m_arvalid));

    p_wlast_place_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && m_wready) |-> (m_wlast == (w_pos == 16'(BURST_BEATS - 1))));

    p_aw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    p_w_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));

    p_irq_after_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (b_seen == 16'(BURSTS)));

    p_irq_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(clear_i && !clr_q)) |=> irq_o);
endmodule

bind fill_master fill_master_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURSTS(BURSTS), .BURST_BEATS(BURST_BEATS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .irq_o     (irq_o),
    .m_awaddr  (m_awaddr),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_wdata   (m_wdata),
    .m_wlast   (m_wlast),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .m_bvalid  (m_bvalid),
    .m_bready  (m_bready),
    .m_arvalid (m_arvalid)
);

// File: tb/fill_master_test.sv
// Bench: plays the memory side with throttled handshakes, walks a vector
// table of slave behaviours, then runs directed handshake tests.
module fill_master_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0000_1000;

    typedef struct packed {
        int aw_gap;
        int w_gap;
        int b_gap;
        int r_gap;
        int err_burst;
        int bad_beat;
        bit exp_resp;
        bit exp_data;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{0, 0, 0, 0, -1, -1, 1'b0, 1'b0},
        '{2, 3, 2, 2, -1, -1, 1'b0, 1'b0},
        '{0, 2, 0, 0,  1, -1, 1'b1, 1'b0},
        '{3, 0, 3, 2, -1,  5, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic clear_i = 1'b0;
    logic irq_o, resp_err_o, data_err_o;
    logic [31:0] m_awaddr, m_araddr;
    logic [7:0]  m_awlen, m_arlen, m_wstrb;
    logic [2:0]  m_awsize, m_arsize;
    logic [1:0]  m_awburst, m_arburst;
    logic m_awvalid, m_wvalid, m_wlast, m_bready, m_arvalid, m_rready;
    logic [63:0] m_wdata;
    logic m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0, m_arready = 1'b0;
    logic m_rvalid = 1'b0, m_rlast = 1'b0;
    logic [1:0] m_bresp = 2'd0, m_rresp = 2'd0;
    logic [63:0] m_rdata = '0;

    int tests = 0, fails = 0, cyc = 0;
    int aw_gap = 0, w_gap = 0, b_gap = 0, r_gap = 0, err_burst = -1, bad_beat = -1;
    logic run_clear = 1'b0;

    // Slave-side bookkeeping, updated at the rising edge.
    logic [63:0] mem [32];
    logic [31:0] aw_log [4];
    logic [31:0] ar_log [4];
    int aw_n, w_burst, w_beat, b_pend, b_n, ar_n, r_burst, r_beat, r_total;
    logic aw_bad, w_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    fill_master uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
        .irq_o(irq_o), .resp_err_o(resp_err_o), .data_err_o(data_err_o),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
        .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    function automatic bit open_slot(int gap);
        return (gap == 0) || ((cyc % gap) != 0);
    endfunction

    function automatic logic [63:0] pattern(int n);
        return {32'(2*n + 1), 32'(2*n)};
    endfunction

    // Capture handshakes and store write data.
    always @(posedge clk) begin
        int bp;
        if (!rst_n || run_clear) begin
            aw_n <= 0; w_burst <= 0; w_beat <= 0; b_pend <= 0; b_n <= 0;
            ar_n <= 0; r_burst <= 0; r_beat <= 0; r_total <= 0;
            aw_bad <= 1'b0; w_bad <= 1'b0;
            if (run_clear) for (int i = 0; i < 32; i++) mem[i] <= 64'hDEAD_BEEF_DEAD_BEEF;
        end else begin
            bp = b_pend;
            if (m_awvalid && m_awready) begin
                if (aw_n < 4) aw_log[aw_n] <= m_awaddr;
                if (m_awaddr != BASE + 32'(aw_n*128) || m_awlen != 8'd15 ||
                    m_awsize != 3'd3 || m_awburst != 2'd1) aw_bad <= 1'b1;
                aw_n <= aw_n + 1;
            end
            if (m_wvalid && m_wready) begin
                int idx;
                idx = int'((aw_log[w_burst] - BASE) >> 3) + w_beat;
                if (idx >= 0 && idx < 32) mem[idx] <= m_wdata;
                if (m_wstrb != 8'hFF || m_wlast != (w_beat == 15)) w_bad <= 1'b1;
                if (w_beat == 15) begin
                    w_beat <= 0; w_burst <= w_burst + 1; bp = bp + 1;
                end else w_beat <= w_beat + 1;
            end
            if (m_bvalid && m_bready) begin
                bp = bp - 1; b_n <= b_n + 1;
            end
            b_pend <= bp;
            if (m_arvalid && m_arready) begin
                if (ar_n < 4) ar_log[ar_n] <= m_araddr;
                ar_n <= ar_n + 1;
            end
            if (m_rvalid && m_rready) begin
                r_total <= r_total + 1;
                if (r_beat == 15) begin r_beat <= 0; r_burst <= r_burst + 1; end
                else r_beat <= r_beat + 1;
            end
        end
    end

    // Drive slave ready/valid away from the active edge.
    always @(negedge clk) begin
        int ridx;
        cyc <= cyc + 1;
        m_awready <= open_slot(aw_gap);
        m_wready  <= (aw_n > w_burst) && (w_burst < 4) && open_slot(w_gap);
        m_bvalid  <= (b_pend > 0) && open_slot(b_gap);
        m_bresp   <= (b_n == err_burst) ? 2'd2 : 2'd0;
        m_arready <= open_slot(r_gap);
        m_rvalid  <= (ar_n > r_burst) && (r_burst < 4) && open_slot(r_gap);
        ridx = (r_burst < 4) ? int'((ar_log[r_burst] - BASE) >> 3) + r_beat : 0;
        if (ridx < 0 || ridx > 31) ridx = 0;
        m_rdata   <= mem[ridx] ^ ((r_total == bad_beat) ? 64'h1 : 64'h0);
        m_rlast   <= (r_beat == 15);
        m_rresp   <= 2'd0;
    end

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; start_i = 1'b0; clear_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fresh_region();
        run_clear = 1'b1; @(negedge clk); run_clear = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1; @(negedge clk); start_i = 1'b0; @(negedge clk);
    endtask

    task automatic wait_irq(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (irq_o) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        if (!seen) check(1'b0, "watchdog irq", 0, 1);
    endtask

    task automatic check_region(string req);
        bit ok = 1'b1;
        int badi = 0;
        for (int i = 0; i < 32; i++)
            if (ok && mem[i] !== pattern(i)) begin ok = 1'b0; badi = i; end
        check(ok, req, mem[badi], pattern(badi));
    endtask

    initial begin
        bit seen;
        int aw_before;
        do_reset();
        // R10: reset state
        check(!irq_o && !resp_err_o && !data_err_o, "R10 flags after reset",
              {irq_o, resp_err_o, data_err_o}, 0);
        check(!m_awvalid && !m_wvalid && !m_arvalid, "R10 valids after reset",
              {m_awvalid, m_wvalid, m_arvalid}, 0);

        // Vector walk over slave behaviours.
        for (int v = 0; v < 4; v++) begin
            aw_gap = VECS[v].aw_gap; w_gap = VECS[v].w_gap;
            b_gap = VECS[v].b_gap; r_gap = VECS[v].r_gap;
            err_burst = VECS[v].err_burst; bad_beat = VECS[v].bad_beat;
            do_reset();
            fresh_region();
            pulse_start();
            wait_irq(seen);
            if (seen) begin
                check(b_n == 2 && r_total == 32, "R6 responses before irq", b_n, 2);
                check(aw_n == 2 && !aw_bad, "R2 write bursts", aw_n, 2);
                check(!w_bad, "R3 strobes and last", w_bad, 0);
                check_region("R4 packed pattern");
                check(ar_n == 2 && ar_log[0] == BASE && ar_log[1] == BASE + 32'h80,
                      "R9 read bursts", ar_n, 2);
                check(resp_err_o == VECS[v].exp_resp, "R8 response flag",
                      resp_err_o, VECS[v].exp_resp);
                check(data_err_o == VECS[v].exp_data, "R9 compare flag",
                      data_err_o, VECS[v].exp_data);
            end
        end

        // Directed: start ignored mid-run, while pending, then clear and rerun.
        aw_gap = 2; w_gap = 2; b_gap = 0; r_gap = 0; err_burst = -1; bad_beat = -1;
        do_reset();
        fresh_region();
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        wait_irq(seen);
        repeat (20) @(negedge clk);
        check(aw_n == 2, "R1 start during run ignored", aw_n, 2);
        aw_before = aw_n;
        pulse_start();
        repeat (30) @(negedge clk);
        check(aw_n == aw_before && irq_o, "R1 start while pending ignored", aw_n, aw_before);
        check(irq_o, "R7 irq held without clear", irq_o, 1);
        clear_i = 1'b1; @(negedge clk); @(negedge clk);
        check(!irq_o, "R7 irq drops after clear", irq_o, 0);
        clear_i = 1'b0;
        @(negedge clk);
        check(!irq_o, "R7 irq stays low while idle", irq_o, 0);
        fresh_region();
        pulse_start();
        wait_irq(seen);
        check(seen, "R7 new interrupt edge", seen, 1);
        check_region("R4 pattern restarts");
        check(!resp_err_o && !data_err_o, "R8 clean rerun flags",
              {resp_err_o, data_err_o}, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule